// File: doc/BRIEF.md
# Side-by-Side Stereo Stream Splitter

This block accepts one raster stream of 16-bit words in which each row carries a left camera image and a right camera image placed next to each other. It separates that stream into two 8-bit luma streams, one per camera. Each output has its own valid/ready pair and marks the last pixel of every line and of every frame. The row count, the total words per input row, the combined active width and the single-image width are runtime inputs. They are captured when the first word of a frame is accepted and are then held until that frame ends.

Routing is by column position within the row. Columns before the single-image width go to the left output. Columns from there up to the combined width go to the right output. Any remaining padding columns up to the row stride are taken from the input and thrown away. Only the low byte of each word is passed on, and the upper byte is dropped. The input stalls only when the output that the current column selects is not ready. Output data, valid and flags are combinational from the input word, so a word moves in the cycle it is accepted.

Top module: `stereo_line_splitter`

## Requirements
- R1: Input columns 0 to width-1 of every row appear on the left output, in order, one word per accepted input word.
- R2: Input columns width to dual_width-1 of every row appear on the right output, in order.
- R3: Each output word equals bits 7:0 of the input word it came from; bits 15:8 never reach an output.
- R4: Columns at or beyond dual_width are accepted with in_ready high whatever the output readies are, and they raise neither output valid.
- R5: left_eol is high only on column width-1 and right_eol only on column dual_width-1.
- R6: left_eof and right_eof are high only on their stream's end-of-line word in the last row, and neither is ever high without the matching eol.
- R7: in_ready is low only while in_valid selects an output whose ready is low; the ready of the other output has no effect on the stall.
- R8: The configuration inputs are sampled with the first accepted word of a frame (row 0, column 0); changes on them later in that frame have no effect on routing, flags or frame length.
- R9: After the last word of the last row, the next accepted word is row 0, column 0 of a new frame. With both outputs ready, one word is accepted every clock, including across a frame boundary.
- R10: After reset, neither output is valid while in_valid is low, and the next word is treated as the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rows | input | DIM_W | Rows per frame |
| cfg_stride | input | DIM_W | Input words per row, including padding |
| cfg_dual_width | input | DIM_W | Active words per row, both images together |
| cfg_width | input | DIM_W | Words per row in one image |
| in_data | input | WORD_W | Input word; luma in the low byte |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| left_data | output | LUMA_W | Left image luma |
| left_valid | output | 1 | Left word valid |
| left_ready | input | 1 | Left consumer ready |
| left_eol | output | 1 | Last left word of a line |
| left_eof | output | 1 | Last left word of a frame |
| right_data | output | LUMA_W | Right image luma |
| right_valid | output | 1 | Right word valid |
| right_ready | input | 1 | Right consumer ready |
| right_eol | output | 1 | Last right word of a line |
| right_eof | output | 1 | Last right word of a frame |

## Verification
Two things happen in the same cycle here. The frame wrap on the last word of the last row lands in the cycle just before the configuration capture of the next frame. Also, the right end-of-line, end-of-frame and the counter wrap all fall on one word when no padding columns exist. The bench sends two frames with different geometries back to back, with no idle cycle between them. It also changes the configuration inputs right after the first word of the earlier frame. Each frame is then judged on its own geometry: pixel counts, luma values, flag positions, and a cycle count equal to the total number of words.

// File: rtl/stereo_line_splitter.sv
module stereo_line_splitter #(
  parameter int DIM_W  = 12,
  parameter int WORD_W = 16,
  parameter int LUMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIM_W-1:0]  cfg_rows,
  input  logic [DIM_W-1:0]  cfg_stride,
  input  logic [DIM_W-1:0]  cfg_dual_width,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [LUMA_W-1:0] left_data,
  output logic              left_valid,
  input  logic              left_ready,
  output logic              left_eol,
  output logic              left_eof,
  output logic [LUMA_W-1:0] right_data,
  output logic              right_valid,
  input  logic              right_ready,
  output logic              right_eol,
  output logic              right_eof
);

  logic [DIM_W-1:0] col_q, row_q;
  logic [DIM_W-1:0] rows_q, stride_q, dual_q, width_q;

  wire at_start = (col_q == '0) && (row_q == '0);

  wire [DIM_W-1:0] rows_e   = at_start ? cfg_rows       : rows_q;
  wire [DIM_W-1:0] stride_e = at_start ? cfg_stride     : stride_q;
  wire [DIM_W-1:0] dual_e   = at_start ? cfg_dual_width : dual_q;
  wire [DIM_W-1:0] width_e  = at_start ? cfg_width      : width_q;

  wire sel_left  = col_q < width_e;
  wire sel_right = !sel_left && (col_q < dual_e);
  wire pad       = !sel_left && !sel_right;

  wire last_col  = col_q == stride_e - 1'b1;
  wire last_row  = row_q == rows_e - 1'b1;

  assign in_ready = pad | (sel_left & left_ready) | (sel_right & right_ready);
  wire accept = in_valid & in_ready;

  assign left_data   = in_data[LUMA_W-1:0];
  assign right_data  = in_data[LUMA_W-1:0];
  assign left_valid  = in_valid & sel_left;
  assign right_valid = in_valid & sel_right;
  assign left_eol    = sel_left  && (col_q == width_e - 1'b1);
  assign right_eol   = sel_right && (col_q == dual_e - 1'b1);
  assign left_eof    = left_eol  && last_row;
  assign right_eof   = right_eol && last_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q    <= '0;
      row_q    <= '0;
      rows_q   <= '0;
      stride_q <= '0;
      dual_q   <= '0;
      width_q  <= '0;
    end else if (accept) begin
      if (at_start) begin
        rows_q   <= cfg_rows;
        stride_q <= cfg_stride;
        dual_q   <= cfg_dual_width;
        width_q  <= cfg_width;
      end
      if (last_col) begin
        col_q <= '0;
        row_q <= last_row ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // R7: a stalled word leaves the raster position untouched
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ($stable(col_q) && $stable(row_q)));

  // R8: captured geometry moves only on a frame-start acceptance
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_start && accept) |=> ($stable(rows_q) && $stable(stride_q) &&
                               $stable(dual_q) && $stable(width_q)));

  // R4: padding columns never drive an output and never stall
  a_r4_pad_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && col_q >= dual_e) |-> (!left_valid && !right_valid && in_ready));

  // R6: end of frame only together with end of line
  a_r6_eof_with_eol: assert property (@(posedge clk) disable iff (!rst_n)
    (left_eof |-> left_eol) and (right_eof |-> right_eol));

  // R1: at most one output is offered a word
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({left_valid, right_valid}));

  // R9: inside a frame the column stays below the captured stride
  a_r9_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |-> (col_q < stride_q));

endmodule

// File: tb/stereo_line_splitter_test.sv
`timescale 1ns/1ps
module stereo_line_splitter_test;
  localparam int DW = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [DW-1:0] cfg_rows = '0, cfg_stride = '0, cfg_dual_width = '0, cfg_width = '0;
  logic [15:0] in_data = '0;
  logic in_valid = 1'b0, left_ready = 1'b0, right_ready = 1'b0;
  logic in_ready, left_valid, left_eol, left_eof, right_valid, right_eol, right_eof;
  logic [7:0] left_data, right_data;

  stereo_line_splitter #(.DIM_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rows(cfg_rows), .cfg_stride(cfg_stride),
    .cfg_dual_width(cfg_dual_width), .cfg_width(cfg_width),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .left_data(left_data), .left_valid(left_valid), .left_ready(left_ready),
    .left_eol(left_eol), .left_eof(left_eof),
    .right_data(right_data), .right_valid(right_valid), .right_ready(right_ready),
    .right_eol(right_eol), .right_eof(right_eof));

  int checks = 0, errors = 0;
  int cyc = 0;
  int rmode = 2;
  int first_acc = -1, last_acc = -1;
  logic [9:0] lq[$], rq[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #0.5;
    if (rmode == 0) begin left_ready = 1'b1; right_ready = 1'b1; end
    else if (rmode == 1) begin
      left_ready  = (cyc % 2) == 0;
      right_ready = (cyc % 3) != 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (left_valid && left_ready)   lq.push_back({left_eof, left_eol, left_data});
    if (right_valid && right_ready) rq.push_back({right_eof, right_eol, right_data});
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [15:0] pw(input int r, input int c);
    return {8'(8'h5A + c), 8'(r * 29 + c * 7 + 3)};
  endfunction

  task automatic put(input logic [15:0] w);
    bit ok;
    in_data = w;
    in_valid = 1'b1;
    do begin
      @(negedge clk);
      ok = in_ready;
      if (ok) begin
        if (first_acc < 0) first_acc = cyc;
        last_acc = cyc;
      end
      @(posedge clk);
      #0.5;
    end while (!ok);
  endtask

  task automatic send_frame(input int R, input int S, input int D, input int W, input bit scramble);
    cfg_rows = DW'(R); cfg_stride = DW'(S); cfg_dual_width = DW'(D); cfg_width = DW'(W);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < S; c++) begin
        put(pw(r, c));
        if (scramble && r == 0 && c == 0) begin
          cfg_rows = 12'd1; cfg_stride = 12'd3; cfg_dual_width = 12'd2; cfg_width = 12'd1;
        end
      end
  endtask

  task automatic check_frame(input int R, input int D, input int W, input string tag);
    int el = 0, er = 0, fl = 0, fr = 0, gl = 0, gr = 0;
    logic [9:0] e;
    chk(lq.size() >= R * W, {"R1 left word count ", tag}, lq.size(), R * W);
    chk(rq.size() >= R * (D - W), {"R2 right word count ", tag}, rq.size(), R * (D - W));
    for (int r = 0; r < R; r++) begin
      for (int c = 0; c < W && lq.size() > 0; c++) begin
        e = lq.pop_front();
        if (e[7:0] != pw(r, c)[7:0]) el++;
        if (e[8] != (c == W - 1)) fl++;
        if (e[9] != (c == W - 1 && r == R - 1)) gl++;
      end
      for (int c = W; c < D && rq.size() > 0; c++) begin
        e = rq.pop_front();
        if (e[7:0] != pw(r, c)[7:0]) er++;
        if (e[8] != (c == D - 1)) fr++;
        if (e[9] != (c == D - 1 && r == R - 1)) gr++;
      end
    end
    chk(el == 0, {"R1 R3 left luma ", tag}, el, 0);
    chk(er == 0, {"R2 R3 right luma ", tag}, er, 0);
    chk(fl + fr == 0, {"R5 eol placement ", tag}, fl + fr, 0);
    chk(gl + gr == 0, {"R6 eof placement ", tag}, gl + gr, 0);
  endtask

  task automatic t_reset();
    rmode = 2;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    chk(!left_valid && !right_valid, "R10 no valid after reset", {left_valid, right_valid}, 0);
    @(posedge clk); #0.5;
  endtask

  task automatic t_basic();
    rmode = 0;
    first_acc = -1;
    send_frame(3, 12, 8, 4, 1'b0);
    in_valid = 1'b0;
    chk(last_acc - first_acc + 1 == 36, "R9 one word per clock", last_acc - first_acc + 1, 36);
    check_frame(3, 8, 4, "basic with padding");
  endtask

  task automatic t_backpressure();
    rmode = 1;
    send_frame(2, 10, 10, 5, 1'b0);
    in_valid = 1'b0;
    check_frame(2, 10, 5, "backpressure, no padding");
  endtask

  task automatic t_midcfg();
    rmode = 0;
    first_acc = -1;
    send_frame(2, 6, 6, 3, 1'b1);
    send_frame(3, 9, 8, 4, 1'b0);
    in_valid = 1'b0;
    chk(last_acc - first_acc + 1 == 39, "R8 R9 back-to-back frame length", last_acc - first_acc + 1, 39);
    check_frame(2, 6, 3, "R8 first frame ignores late cfg");
    check_frame(3, 8, 4, "R9 second frame fresh cfg");
    chk(lq.size() == 0 && rq.size() == 0, "R8 no extra words", lq.size() + rq.size(), 0);
  endtask

  task automatic t_stall();
    logic [9:0] e;
    rmode = 2;
    cfg_rows = 12'd1; cfg_stride = 12'd4; cfg_dual_width = 12'd2; cfg_width = 12'd1;
    left_ready = 1'b0; right_ready = 1'b1;
    in_data = pw(0, 0); in_valid = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(!in_ready && left_valid, "R7 stall on left, right ready ignored", in_ready, 0);
    end
    @(posedge clk); #0.5 left_ready = 1'b1;
    @(negedge clk);
    chk(in_ready, "R7 left ready releases", in_ready, 1);
    @(posedge clk); #0.5 in_data = pw(0, 1); right_ready = 1'b0;
    @(negedge clk);
    chk(!in_ready && right_valid, "R7 stall on right, left ready ignored", in_ready, 0);
    @(posedge clk); #0.5 right_ready = 1'b1;
    @(negedge clk);
    @(posedge clk); #0.5 in_data = pw(0, 2); left_ready = 1'b0; right_ready = 1'b0;
    @(negedge clk);
    chk(in_ready && !left_valid && !right_valid, "R4 pad consumed with outputs blocked",
        {in_ready, left_valid, right_valid}, 4);
    @(posedge clk); #0.5 in_data = pw(0, 3);
    @(negedge clk);
    chk(in_ready, "R4 second pad consumed", in_ready, 1);
    @(posedge clk); #0.5 in_valid = 1'b0;
    chk(lq.size() == 1 && rq.size() == 1, "R4 pads produced no output", lq.size() + rq.size(), 2);
    if (lq.size() > 0) begin
      e = lq.pop_front();
      chk(e == {2'b11, pw(0, 0)[7:0]}, "R6 single-row left eof", e, {2'b11, pw(0, 0)[7:0]});
    end
    if (rq.size() > 0) begin
      e = rq.pop_front();
      chk(e == {2'b11, pw(0, 1)[7:0]}, "R6 single-row right eof", e, {2'b11, pw(0, 1)[7:0]});
    end
  endtask

  initial begin
    t_reset();
    t_stall();
    t_basic();
    t_backpressure();
    t_midcfg();
    repeat (4) @(posedge clk);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    report();
  end
endmodule